// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a two-level page table that sits in ordinary memory. Pages are 1 KB, so the low 10 bits of the address pass straight through as the offset. The remaining 22-bit page number is cut into a 12-bit upper index that picks an entry of the top-level table and a 10-bit lower index that picks an entry of the second-level table that the first entry points to.

A requester hands over an address together with the frame number of the top-level table and waits for a single response carrying either the physical address or a fault. The walker reads the top-level entry, checks its valid flag, reads the second-level entry, checks that flag too, and finally joins the returned frame number with the offset. Table memory is reached through a read port that never has more than one read in flight. Each successful translation costs exactly two table reads. A fault stops the walk at the level that failed and reports that level.

Top module: `pt_walker`

## Requirements
- R1: After synchronous active-low reset the walker is idle: `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: The first table read goes to byte address `{req_root, 10'b0} + 4 * vaddr[31:20]`, with `req_root` sampled when the request is accepted.
- R3: A table entry is a 32-bit word whose bit 0 is the valid flag and whose bits 31:10 hold the next frame number; bits 9:1 are ignored. The second read goes to `{entry1[31:10], 10'b0} + 4 * vaddr[19:10]`.
- R4: When both entries are valid the response has `rsp_fault` 0 and `rsp_paddr = {entry2[31:10], vaddr[9:0]}`, after exactly two table reads.
- R5: When the first entry has bit 0 clear the response has `rsp_fault` 1 and `rsp_fault_level` 0, and no second read is issued.
- R6: When the second entry has bit 0 clear the response has `rsp_fault` 1 and `rsp_fault_level` 1, after two reads.
- R7: At most one table read is outstanding; `mem_req_valid` and `mem_req_addr` stay unchanged while `mem_req_ready` is 0, and no further read is issued before the pending one returns.
- R8: A request is accepted only while idle (`req_ready` 1); a request presented during a walk or while a response waits is ignored and causes no table read.
- R9: `rsp_valid`, `rsp_paddr`, `rsp_fault` and `rsp_fault_level` hold steady until `rsp_ready` is 1; the walker is idle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Logical address to translate |
| req_root | input | 22 | Frame number of the top-level table |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Physical address (meaningful when no fault) |
| rsp_fault | output | 1 | Translation failed on an invalid entry |
| rsp_fault_level | output | 1 | Level of the failed entry: 0 top, 1 second |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data present (one cycle) |
| mem_rsp_data | input | 32 | Table entry returned |

## Verification
The assertions take for granted that memory raises `mem_rsp_valid` for a single cycle only while one accepted read is still unanswered, never unprompted and never twice for one read. The bench memory model records each accepted read and answers it exactly once after a programmable latency, with back-pressure on `mem_req_ready` applied from separate stall control. Requester inputs change only between clock edges, so the hold checks on the response see a stable `rsp_ready`.

// File: rtl/pt_walk_pkg.sv
// Package: shared types for the page table walker.
// Assumes: nothing beyond SystemVerilog enum support.
package pt_walk_pkg;

    // Walk sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OUTER = 2'd1,
        ST_INNER = 2'd2,
        ST_DONE  = 2'd3
    } walk_state_t;

    // Fault level encoding reported to the requester.
    typedef enum logic {
        LVL_OUTER = 1'b0,
        LVL_INNER = 1'b1
    } fault_level_t;

endpackage

// File: rtl/pt_va_split.sv
// Module: pt_va_split
// Cuts a logical address into upper index, lower index and page offset.
// Assumes: OUTER_W + OFF_W < VA_W so the lower index is at least one bit.
module pt_va_split #(
    parameter int VA_W    = 32,
    parameter int OFF_W   = 10,
    parameter int OUTER_W = 12,
    localparam int INNER_W = VA_W - OFF_W - OUTER_W
) (
    input  logic [VA_W-1:0]    vaddr,
    output logic [OUTER_W-1:0] outer_idx,
    output logic [INNER_W-1:0] inner_idx,
    output logic [OFF_W-1:0]   offset
);

    // Field extraction: upper bits index the top table, middle bits the second.
    always_comb begin
        outer_idx = vaddr[VA_W-1 -: OUTER_W];
        inner_idx = vaddr[OFF_W +: INNER_W];
        offset    = vaddr[OFF_W-1:0];
    end

endmodule

// File: rtl/pt_entry_addr.sv
// Module: pt_entry_addr
// Forms the byte address of a table entry from a frame base and an index.
// Assumes: entries are ENTRY_W/8 bytes, a power of two; tables start on a frame.
module pt_entry_addr #(
    parameter int PA_W    = 32,
    parameter int OFF_W   = 10,
    parameter int IDX_W   = 12,
    parameter int ENTRY_W = 32,
    localparam int FRAME_W     = PA_W - OFF_W,
    localparam int ENTRY_BYTES = ENTRY_W / 8,
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES)
) (
    input  logic [FRAME_W-1:0] base,
    input  logic [IDX_W-1:0]   idx,
    output logic [PA_W-1:0]    addr
);

    logic [PA_W-1:0] base_bytes;
    logic [PA_W-1:0] idx_bytes;

    // Frame base in bytes plus index scaled by the entry size.
    always_comb begin
        base_bytes = {base, {OFF_W{1'b0}}};
        idx_bytes  = PA_W'(idx) << ENTRY_SHIFT;
        addr       = base_bytes + idx_bytes;
    end

endmodule

// File: rtl/pt_entry_decode.sv
// Module: pt_entry_decode
// Splits a returned table entry into its valid flag and frame number.
// Assumes: frame number occupies the top FRAME_W bits of the entry.
module pt_entry_decode #(
    parameter int ENTRY_W   = 32,
    parameter int FRAME_W   = 22,
    parameter int VALID_BIT = 0
) (
    input  logic [ENTRY_W-1:0] entry,
    output logic               valid,
    output logic [FRAME_W-1:0] frame
);

    logic unused_entry_bits;

    // Field pick; the bits between flag and frame carry no meaning here.
    always_comb begin
        valid             = entry[VALID_BIT];
        frame             = entry[ENTRY_W-1 -: FRAME_W];
        unused_entry_bits = ^entry;
    end

endmodule

// File: rtl/pt_walk_ctrl.sv
// Module: pt_walk_ctrl
// Sequences the walk: accept, top read, second read, respond.
// Assumes: memory answers each accepted read exactly once, one cycle wide.
module pt_walk_ctrl
    import pt_walk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic req_ready,
    output logic rsp_valid,
    input  logic rsp_ready,
    output logic mem_req_valid,
    input  logic mem_req_ready,
    input  logic mem_rsp_valid,
    input  logic entry_valid,
    output logic accept,
    output logic outer_load,
    output logic inner_load,
    output logic fault_load,
    output logic at_inner
);

    walk_state_t state_q, state_d;
    logic        sent_q, sent_d;
    logic        reading;
    logic        rsp_take;

    // Decode of the current state into handshake and load strobes.
    always_comb begin
        reading       = (state_q == ST_OUTER) || (state_q == ST_INNER);
        at_inner      = (state_q == ST_INNER);
        req_ready     = (state_q == ST_IDLE);
        rsp_valid     = (state_q == ST_DONE);
        mem_req_valid = reading && !sent_q;
        accept        = req_ready && req_valid;
        rsp_take      = reading && sent_q && mem_rsp_valid;
        outer_load    = rsp_take && !at_inner && entry_valid;
        inner_load    = rsp_take && at_inner && entry_valid;
        fault_load    = rsp_take && !entry_valid;
    end

    // Next-state and read-pending flag computation.
    always_comb begin
        state_d = state_q;
        sent_d  = sent_q;
        if (mem_req_valid && mem_req_ready) begin
            sent_d = 1'b1;
        end
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_OUTER;
                    sent_d  = 1'b0;
                end
            end
            ST_OUTER: begin
                if (outer_load) begin
                    state_d = ST_INNER;
                    sent_d  = 1'b0;
                end else if (fault_load) begin
                    state_d = ST_DONE;
                end
            end
            ST_INNER: begin
                if (inner_load || fault_load) begin
                    state_d = ST_DONE;
                end
            end
            default: begin
                if (rsp_ready) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sent_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            sent_q  <= sent_d;
        end
    end

    // R7: an accepted read is followed by no new request in the next cycle.
    a_r7_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    // R7: an unaccepted read request stays raised.
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid);

    // R7 input assumption: memory data only arrives for a pending read.
    a_r7_rsp_expected: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> (reading && sent_q));

    // R8: idle never overlaps a pending result or a table read.
    a_r8_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rsp_valid && !mem_req_valid));

    // R9: an unaccepted result stays presented.
    a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> rsp_valid);

    // R9: a taken result returns the walker to idle.
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> req_ready);

endmodule

// File: rtl/pt_walker.sv
// Module: pt_walker (top)
// Two-level page table walker with a single-outstanding table read port.
// Assumes: the top table is contiguous from frame req_root; memory returns
// one response per accepted read.
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int OFF_W     = 10,
    parameter int OUTER_W   = 12,
    parameter int ENTRY_W   = 32,
    parameter int VALID_BIT = 0,
    localparam int FRAME_W  = PA_W - OFF_W,
    localparam int INNER_W  = VA_W - OFF_W - OUTER_W,
    localparam int IDX_W    = (OUTER_W > INNER_W) ? OUTER_W : INNER_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [FRAME_W-1:0] req_root,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic               rsp_fault,
    output logic               rsp_fault_level,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data
);

    logic [VA_W-1:0]    vaddr_q;
    logic [FRAME_W-1:0] root_q;
    logic [FRAME_W-1:0] next_base_q;
    logic [PA_W-1:0]    paddr_q;
    logic               fault_q;
    fault_level_t       level_q;

    logic [OUTER_W-1:0] outer_idx;
    logic [INNER_W-1:0] inner_idx;
    logic [OFF_W-1:0]   offset;
    logic               entry_valid;
    logic [FRAME_W-1:0] entry_frame;
    logic [FRAME_W-1:0] sel_base;
    logic [IDX_W-1:0]   sel_idx;
    logic               accept, outer_load, inner_load, fault_load, at_inner;

    pt_va_split #(
        .VA_W    (VA_W),
        .OFF_W   (OFF_W),
        .OUTER_W (OUTER_W)
    ) u_split (
        .vaddr     (vaddr_q),
        .outer_idx (outer_idx),
        .inner_idx (inner_idx),
        .offset    (offset)
    );

    pt_entry_decode #(
        .ENTRY_W   (ENTRY_W),
        .FRAME_W   (FRAME_W),
        .VALID_BIT (VALID_BIT)
    ) u_decode (
        .entry (mem_rsp_data),
        .valid (entry_valid),
        .frame (entry_frame)
    );

    // Table and index selection for the level being read.
    always_comb begin
        sel_base = at_inner ? next_base_q : root_q;
        sel_idx  = at_inner ? IDX_W'(inner_idx) : IDX_W'(outer_idx);
    end

    pt_entry_addr #(
        .PA_W    (PA_W),
        .OFF_W   (OFF_W),
        .IDX_W   (IDX_W),
        .ENTRY_W (ENTRY_W)
    ) u_addr (
        .base (sel_base),
        .idx  (sel_idx),
        .addr (mem_req_addr)
    );

    pt_walk_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .entry_valid   (entry_valid),
        .accept        (accept),
        .outer_load    (outer_load),
        .inner_load    (inner_load),
        .fault_load    (fault_load),
        .at_inner      (at_inner)
    );

    // Request capture and second-level base from the top entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q     <= '0;
            root_q      <= '0;
            next_base_q <= '0;
        end else begin
            if (accept) begin
                vaddr_q <= req_vaddr;
                root_q  <= req_root;
            end
            if (outer_load) begin
                next_base_q <= entry_frame;
            end
        end
    end

    // Result registers: physical address or fault with its level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q <= '0;
            fault_q <= 1'b0;
            level_q <= LVL_OUTER;
        end else if (inner_load) begin
            paddr_q <= {entry_frame, offset};
            fault_q <= 1'b0;
            level_q <= LVL_OUTER;
        end else if (fault_load) begin
            paddr_q <= '0;
            fault_q <= 1'b1;
            level_q <= at_inner ? LVL_INNER : LVL_OUTER;
        end
    end

    assign rsp_paddr       = paddr_q;
    assign rsp_fault       = fault_q;
    assign rsp_fault_level = level_q;

    // R7: the read address stays put while memory holds off.
    a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));

    // R9: a waiting result keeps its contents.
    a_r9_rsp_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> ($stable(rsp_paddr) && $stable(rsp_fault)
                                       && $stable(rsp_fault_level)));

    // R5: a failing top entry yields a level-0 fault.
    a_r5_outer_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_load && !at_inner) |=> (rsp_valid && rsp_fault && !rsp_fault_level));

    // R6: a failing second entry yields a level-1 fault.
    a_r6_inner_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_load && at_inner) |=> (rsp_valid && rsp_fault && rsp_fault_level));

    // R4: a good result carries the request offset through unchanged.
    a_r4_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]));

endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic [21:0] req_root;
    logic        rsp_valid;
    logic        rsp_ready;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        rsp_fault_level;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    int errors = 0;
    int checks = 0;

    // Memory model state.
    logic [31:0] pmem [logic [31:0]];
    int          nreads;
    logic [31:0] rd_addr [0:3];
    int          mem_lat;
    bit          mem_stall;
    bit          mbusy;
    int          mcnt;
    logic [31:0] maddr;

    always #10 clk = ~clk;

    pt_walker i_pt_walker (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_vaddr       (req_vaddr),
        .req_root        (req_root),
        .rsp_valid       (rsp_valid),
        .rsp_ready       (rsp_ready),
        .rsp_paddr       (rsp_paddr),
        .rsp_fault       (rsp_fault),
        .rsp_fault_level (rsp_fault_level),
        .mem_req_valid   (mem_req_valid),
        .mem_req_ready   (mem_req_ready),
        .mem_req_addr    (mem_req_addr),
        .mem_rsp_valid   (mem_rsp_valid),
        .mem_rsp_data    (mem_rsp_data)
    );

    assign mem_req_ready = !mem_stall;

    // Table memory: one answer per accepted read, after mem_lat cycles.
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        mbusy         = 1'b0;
        mcnt          = 0;
        maddr         = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mbusy) begin
                if (mcnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pmem.exists(maddr) ? pmem[maddr] : 32'h0;
                    mbusy         = 1'b0;
                end else begin
                    mcnt = mcnt - 1;
                end
            end else if (rst_n && mem_req_valid && mem_req_ready) begin
                maddr = mem_req_addr;
                if (nreads < 4) rd_addr[nreads] = maddr;
                nreads = nreads + 1;
                mbusy  = 1'b1;
                mcnt   = mem_lat;
            end
        end
    end

    function automatic logic [31:0] exp_top(input logic [31:0] va, input logic [21:0] root);
        return {root, 10'b0} + {18'b0, va[31:20], 2'b00};
    endfunction

    function automatic logic [31:0] exp_second(input logic [31:0] va, input logic [31:0] e1);
        return {e1[31:10], 10'b0} + {20'b0, va[19:10], 2'b00};
    endfunction

    function automatic logic [31:0] mk_entry(input logic [21:0] frame, input logic [8:0] junk,
                                             input logic valid);
        return {frame, junk, valid};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input logic [31:0] va, input logic [21:0] root);
        step();
        nreads    = 0;
        req_vaddr = va;
        req_root  = root;
        req_valid = 1'b1;
        step();
        req_valid = 1'b0;
        req_vaddr = 32'hDEAD_BEEF;
        req_root  = 22'h3F_FFFF;
    endtask

    task automatic wait_rsp();
        do @(negedge clk); while (!rsp_valid);
    endtask

    // Full walk with result, read count and read address checks.
    task automatic walk_check(input logic [31:0] va, input logic [21:0] root,
                              input bit exp_fault, input bit exp_lvl,
                              input logic [31:0] exp_pa, input int exp_reads,
                              input string tag);
        logic [31:0] a1;
        rsp_ready = 1'b1;
        issue(va, root);
        wait_rsp();
        a1 = exp_top(va, root);
        chk(rsp_fault == exp_fault, {tag, " fault"}, 32'(rsp_fault), 32'(exp_fault));
        if (exp_fault)
            chk(rsp_fault_level == exp_lvl, {tag, " level"}, 32'(rsp_fault_level), 32'(exp_lvl));
        else
            chk(rsp_paddr == exp_pa, {tag, " paddr"}, rsp_paddr, exp_pa);
        chk(nreads == exp_reads, {tag, " reads"}, 32'(nreads), 32'(exp_reads));
        chk(rd_addr[0] == a1, "R2 top entry address", rd_addr[0], a1);
        if (exp_reads == 2)
            chk(rd_addr[1] == exp_second(va, pmem[a1]), "R3 second entry address",
                rd_addr[1], exp_second(va, pmem[a1]));
        step();
    endtask

    task automatic t_reset();
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_vaddr = '0;
        req_root  = '0;
        rsp_ready = 1'b1;
        mem_lat   = 0;
        mem_stall = 1'b0;
        nreads    = 0;
        repeat (3) step();
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 32'(mem_req_valid), 32'd0);
    endtask

    // R2 R3 R4: ordinary translation, then all-ones indices and offset.
    task automatic t_success();
        pmem[32'h0000_400C] = mk_entry(22'h00020, 9'h000, 1'b1);
        pmem[32'h0000_8014] = mk_entry(22'h12345, 9'h000, 1'b1);
        mem_lat = 2;
        walk_check({12'h003, 10'h005, 10'h123}, 22'h00010, 1'b0, 1'b0,
                   {22'h12345, 10'h123}, 2, "R4 basic");
        pmem[32'h0004_3FFC] = mk_entry(22'h00200, 9'h1FF, 1'b1);
        pmem[32'h0008_0FFC] = mk_entry(22'h2AAAA, 9'h1A5, 1'b1);
        mem_lat = 0;
        walk_check(32'hFFFF_FFFF, 22'h00100, 1'b0, 1'b0,
                   {22'h2AAAA, 10'h3FF}, 2, "R4 R3 max indices");
        pmem[32'h0000_0000] = mk_entry(22'h00001, 9'h000, 1'b1);
        pmem[32'h0000_0400] = mk_entry(22'h3FFFF, 9'h000, 1'b1);
        walk_check(32'h0000_0000, 22'h00000, 1'b0, 1'b0,
                   {22'h3FFFF, 10'h000}, 2, "R4 zero address");
    endtask

    // R5 top fault, R6 second fault (bits 9:1 set but bit 0 clear).
    task automatic t_faults();
        pmem[32'h0000_C07C] = mk_entry(22'h00040, 9'h1FF, 1'b0);
        walk_check({12'h01F, 10'h001, 10'h000}, 22'h00030, 1'b1, 1'b0, 32'h0, 1, "R5 top invalid");
        pmem[32'h0000_C080] = mk_entry(22'h00050, 9'h000, 1'b1);
        pmem[32'h0001_4008] = mk_entry(22'h0ABCD, 9'h0FF, 1'b0);
        mem_lat = 3;
        walk_check({12'h020, 10'h002, 10'h0AA}, 22'h00030, 1'b1, 1'b1, 32'h0, 2, "R6 second invalid");
    endtask

    // R7: read held under back-pressure, one read at a time.
    task automatic t_stall();
        logic [31:0] va;
        va = {12'h003, 10'h005, 10'h2F0};
        mem_stall = 1'b1;
        mem_lat   = 4;
        rsp_ready = 1'b1;
        issue(va, 22'h00010);
        repeat (4) @(negedge clk);
        chk(mem_req_valid == 1'b1, "R7 request held", 32'(mem_req_valid), 32'd1);
        chk(mem_req_addr == 32'h0000_400C, "R7 address held", mem_req_addr, 32'h0000_400C);
        chk(nreads == 0, "R7 no read while stalled", 32'(nreads), 32'd0);
        step();
        mem_stall = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(mem_req_valid == 1'b0, "R7 single outstanding", 32'(mem_req_valid), 32'd0);
        chk(nreads == 1, "R7 one read in flight", 32'(nreads), 32'd1);
        wait_rsp();
        chk(rsp_paddr == {22'h12345, 10'h2F0}, "R7 result after stall",
            rsp_paddr, {22'h12345, 10'h2F0});
        chk(nreads == 2, "R7 read count", 32'(nreads), 32'd2);
        step();
    endtask

    // R8 request during walk ignored; R9 result held until taken.
    task automatic t_busy_hold();
        logic [31:0] held;
        mem_lat   = 5;
        rsp_ready = 1'b0;
        issue({12'h003, 10'h005, 10'h011}, 22'h00010);
        req_vaddr = 32'hFFFF_FFFF;
        req_root  = 22'h00100;
        req_valid = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b0, "R8 busy not ready", 32'(req_ready), 32'd0);
        wait_rsp();
        held = rsp_paddr;
        chk(held == {22'h12345, 10'h011}, "R8 first request served", held, {22'h12345, 10'h011});
        repeat (4) @(negedge clk);
        chk(rsp_valid == 1'b1, "R9 rsp_valid held", 32'(rsp_valid), 32'd1);
        chk(rsp_paddr == held, "R9 paddr held", rsp_paddr, held);
        chk(req_ready == 1'b0, "R8 not ready while result waits", 32'(req_ready), 32'd0);
        chk(nreads == 2, "R8 no read for ignored request", 32'(nreads), 32'd2);
        chk(rd_addr[0] == 32'h0000_400C, "R8 reads belong to first request",
            rd_addr[0], 32'h0000_400C);
        step();
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        step();
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 idle after take", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R9 rsp dropped after take", 32'(rsp_valid), 32'd0);
        repeat (3) @(negedge clk);
        chk(nreads == 2, "R8 no late read", 32'(nreads), 32'd2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_success();
        t_faults();
        t_stall();
        t_busy_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule